// File: doc/BRIEF.md
# Split-Width Atomic Register Access Unit

This unit sits between a host bus and a bank of 32-bit timer registers. The host can issue either 16-bit or 32-bit reads and writes. On the write side, the unit sorts each target register into one of two classes.

- A configuration-class register takes each 16-bit half as soon as that half arrives.
- A functional-class register keeps a lower-half write in a per-register staging slot. It changes only when the matching upper half arrives, and then both halves land in one cycle.

On the read side, some registers change on their own, such as a running counter and capture registers. For these, a 16-bit lower-half read also stores the upper 16 bits in a snapshot kept for that register. The following upper-half read returns that snapshot instead of the live bits.

A second master using 32-bit accesses may interleave with a 16-bit sequence. Its accesses leave staging slots and snapshots of other registers untouched. Register classes are set by two parameter masks. `FUNC_MASK` marks the functional registers, and `SNAP_MASK` marks the registers that need a coherent snapshot.

Top module: `halfword_access_bridge`

## Requirements
- R1: A 32-bit write (`h_wide`=1) raises `reg_we` for the addressed register in the same cycle, with `reg_wstrb`=2'b11 and `reg_wdata`=`h_wdata`. For a functional register it also discards any staged lower half, so a later lone upper-half write changes nothing.
- R2: A 16-bit write carries its data on `h_wdata[15:0]`, and `h_hi`=1 selects the upper half. To a configuration-class register, a lower-half write updates only bits 15:0 (`reg_wstrb`=2'b01) in the same cycle. An upper-half write updates only bits 31:16 (`reg_wstrb`=2'b10).
- R3: A 16-bit lower-half write to a functional register produces no register update and is held in that register's staging slot.
- R4: A 16-bit upper-half write to a functional register with a staged lower half writes {upper, staged lower} in one cycle with `reg_wstrb`=2'b11, and then clears the staged state.
- R5: A 16-bit upper-half write to a functional register with nothing staged has no effect on the register.
- R6: A 32-bit write to another register between the two halves of a functional-register sequence leaves the staged lower half intact.
- R7: For a snapshot register, a 16-bit lower-half read returns bits 15:0 and stores bits 31:16. The next upper-half read of that register returns the stored bits, even if the register has changed since.
- R8: Each snapshot register keeps its own snapshot. Lower-half reads of other registers do not replace it, and neither do 32-bit reads.
- R9: A 32-bit read returns the live 32-bit value. An upper-half read of a non-snapshot register returns the live bits 31:16.
- R10: Read data appears on `h_rdata` in the cycle after the `h_rd` strobe. A 16-bit read returns its data in bits 15:0 with bits 31:16 zero. After reset `h_rdata` is zero, nothing is staged and all snapshots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | AW | Register index |
| h_wdata | input | 32 | Write data; a 16-bit access uses bits 15:0 |
| h_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| h_hi | input | 1 | For 16-bit access: 1 = upper half, 0 = lower half |
| h_wr | input | 1 | Write strobe |
| h_rd | input | 1 | Read strobe |
| h_rdata | output | 32 | Read data, registered |
| reg_val | input | NREG*32 | Current value of every register, register i at bits i*32+31:i*32 |
| reg_we | output | NREG | One-hot update enable per register |
| reg_wstrb | output | 2 | Half enables for the update: bit 0 = bits 15:0, bit 1 = bits 31:16 |
| reg_wdata | output | 32 | Update value |

## Verification
The hardest case to reach is an upper-half read that must return stale bits. This needs a snapshot register whose upper half changes between the lower-half read and the upper-half read. The stimulus gets there in two ways:

- It loads the counter just below a 16-bit carry, lets it run, and reads the halves several cycles apart.
- It rewrites a capture register with a 32-bit access between its two half reads, with a lower-half read of the other capture register in between.

A behavioural model of the register file and access rules is compared with the bench-side bank and with the read data on every clock.

// File: rtl/halfword_access_bridge.sv
module halfword_access_bridge #(
  parameter int NREG = 8,
  parameter logic [NREG-1:0] FUNC_MASK = 8'hF0,
  parameter logic [NREG-1:0] SNAP_MASK = 8'h2C,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     h_addr,
  input  logic [31:0]       h_wdata,
  input  logic              h_wide,
  input  logic              h_hi,
  input  logic              h_wr,
  input  logic              h_rd,
  output logic [31:0]       h_rdata,
  input  logic [NREG*32-1:0] reg_val,
  output logic [NREG-1:0]   reg_we,
  output logic [1:0]        reg_wstrb,
  output logic [31:0]       reg_wdata
);

  logic [NREG-1:0] pend;
  logic [15:0]     stage [NREG];
  logic [15:0]     snap  [NREG];

  wire is_func = FUNC_MASK[h_addr];
  wire is_snap = SNAP_MASK[h_addr];

  wire wr_full = h_wr & h_wide;
  wire wr_lo   = h_wr & ~h_wide & ~h_hi;
  wire wr_hi   = h_wr & ~h_wide & h_hi;
  wire rd_lo   = h_rd & ~h_wide & ~h_hi;

  wire cfg_lo  = wr_lo & ~is_func;
  wire cfg_hi  = wr_hi & ~is_func;
  wire commit  = wr_hi & is_func & pend[h_addr];
  wire fire    = wr_full | cfg_lo | cfg_hi | commit;

  assign reg_we    = fire ? (NREG'(1) << h_addr) : '0;
  assign reg_wstrb = (wr_full | commit) ? 2'b11 :
                     cfg_hi ? 2'b10 :
                     cfg_lo ? 2'b01 : 2'b00;
  assign reg_wdata = wr_full ? h_wdata :
                     commit  ? {h_wdata[15:0], stage[h_addr]} :
                               {h_wdata[15:0], h_wdata[15:0]};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    wire sel = (h_addr == AW'(i));
    if (FUNC_MASK[i]) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend[i]  <= 1'b0;
          stage[i] <= '0;
        end else if (h_wr && sel) begin
          if (wr_lo) begin
            pend[i]  <= 1'b1;
            stage[i] <= h_wdata[15:0];
          end else begin
            pend[i]  <= 1'b0;
          end
        end
      end
    end else begin : g_nostage
      assign pend[i]  = 1'b0;
      assign stage[i] = '0;
    end
    if (SNAP_MASK[i]) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          snap[i] <= '0;
        else if (rd_lo && sel)
          snap[i] <= reg_val[i*32+16 +: 16];
      end
    end else begin : g_nosnap
      assign snap[i] = '0;
    end
  end

  wire [31:0] cur = reg_val[h_addr*32 +: 32];
  wire [31:0] rd_next = h_wide ? cur :
                        h_hi   ? {16'h0, is_snap ? snap[h_addr] : cur[31:16]} :
                                 {16'h0, cur[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      h_rdata <= '0;
    else if (h_rd)
      h_rdata <= rd_next;
  end

endmodule

module halfword_access_bridge_chk #(
  parameter int NREG = 8,
  parameter logic [NREG-1:0] FUNC_MASK = 8'hF0,
  localparam int AW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   h_addr,
  input logic            h_wide,
  input logic            h_hi,
  input logic            h_wr,
  input logic            h_rd,
  input logic [31:0]     h_rdata,
  input logic [NREG-1:0] reg_we,
  input logic [1:0]      reg_wstrb
);

  p_single_update_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we));

  p_wide_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_wide) |-> (reg_we[h_addr] && reg_wstrb == 2'b11));

  p_cfg_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !h_wide && !h_hi && !FUNC_MASK[h_addr]) |-> (reg_we[h_addr] && reg_wstrb == 2'b01));

  p_cfg_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !h_wide && h_hi && !FUNC_MASK[h_addr]) |-> (reg_we[h_addr] && reg_wstrb == 2'b10));

  p_stage_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !h_wide && !h_hi && FUNC_MASK[h_addr]) |-> (reg_we == '0));

  p_commit_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !h_wide && h_hi && FUNC_MASK[h_addr] && reg_we != '0) |-> (reg_wstrb == 2'b11));

  p_no_update_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wr |-> (reg_we == '0));

  p_half_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && !h_wide) |=> (h_rdata[31:16] == 16'h0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> $stable(h_rdata));

endmodule

bind halfword_access_bridge halfword_access_bridge_chk #(.NREG(NREG), .FUNC_MASK(FUNC_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wide(h_wide), .h_hi(h_hi),
  .h_wr(h_wr), .h_rd(h_rd), .h_rdata(h_rdata), .reg_we(reg_we), .reg_wstrb(reg_wstrb)
);

// File: tb/test_halfword_access_bridge.sv
module test_halfword_access_bridge;
  localparam int NREG = 8;
  localparam int AW = 3;
  localparam int CNT = 5;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic h_wide = 0, h_hi = 0, h_wr = 0, h_rd = 0;
  logic [31:0] h_rdata;
  logic [NREG*32-1:0] reg_val;
  logic [NREG-1:0] reg_we;
  logic [1:0] reg_wstrb;
  logic [31:0] reg_wdata;
  logic cnt_run = 0, cap_ev = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  halfword_access_bridge i_halfword_access_bridge (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata), .h_wide(h_wide),
    .h_hi(h_hi), .h_wr(h_wr), .h_rd(h_rd), .h_rdata(h_rdata), .reg_val(reg_val),
    .reg_we(reg_we), .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata));

  logic [31:0] bank [NREG];
  always_comb for (int i = 0; i < NREG; i++) reg_val[i*32 +: 32] = bank[i];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (reg_we[i])
          bank[i] <= {reg_wstrb[1] ? reg_wdata[31:16] : bank[i][31:16],
                      reg_wstrb[0] ? reg_wdata[15:0]  : bank[i][15:0]};
        else if (i == CNT && cnt_run) bank[i] <= bank[i] + 1;
        else if (i == 2 && cap_ev) bank[i] <= bank[CNT];
        else if (i == 3 && cap_ev) bank[i] <= bank[CNT] ^ 32'hFFFF0000;
      end
    end
  end

  logic [31:0] mbank [NREG];
  logic [15:0] mstage [NREG];
  logic [15:0] msnap [NREG];
  bit mpend [NREG];
  logic [31:0] exp_rd;

  always @(posedge clk) begin
    logic [31:0] nb [NREG];
    int a;
    bit func, snp;
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        mbank[i] <= '0; mstage[i] = '0; msnap[i] = '0; mpend[i] = 0;
      end
      exp_rd <= '0;
    end else begin
      a = int'(h_addr);
      func = (a >= 4);
      snp = (a == 2 || a == 3 || a == CNT);
      nb = mbank;
      if (cnt_run) nb[CNT] = mbank[CNT] + 1;
      if (cap_ev) begin
        nb[2] = mbank[CNT];
        nb[3] = mbank[CNT] ^ 32'hFFFF0000;
      end
      if (h_wr) begin
        if (h_wide) begin
          nb[a] = h_wdata; mpend[a] = 0;
        end else if (!h_hi) begin
          if (func) begin mstage[a] = h_wdata[15:0]; mpend[a] = 1; end
          else nb[a] = {mbank[a][31:16], h_wdata[15:0]};
        end else begin
          if (func) begin
            if (mpend[a]) nb[a] = {h_wdata[15:0], mstage[a]};
            mpend[a] = 0;
          end else nb[a] = {h_wdata[15:0], mbank[a][15:0]};
        end
      end
      if (h_rd) begin
        if (h_wide) exp_rd <= mbank[a];
        else if (!h_hi) begin
          exp_rd <= {16'h0, mbank[a][15:0]};
          if (snp) msnap[a] = mbank[a][31:16];
        end else exp_rd <= {16'h0, snp ? msnap[a] : mbank[a][31:16]};
      end
      mbank <= nb;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    for (int i = 0; i < NREG; i++)
      chk(bank[i] === mbank[i], "bank model R1 R2 R3 R4 R5 R6", bank[i], mbank[i]);
    chk(h_rdata === exp_rd, "read model R7 R8 R9 R10", h_rdata, exp_rd);
  end

  task automatic wr(input int a, input bit wide, input bit hi, input logic [31:0] d);
    @(negedge clk);
    h_addr = AW'(a); h_wide = wide; h_hi = hi; h_wdata = d; h_wr = 1;
    @(negedge clk);
    h_wr = 0;
  endtask

  task automatic rd(input int a, input bit wide, input bit hi, output logic [31:0] d);
    @(negedge clk);
    h_addr = AW'(a); h_wide = wide; h_hi = hi; h_rd = 1;
    @(negedge clk);
    h_rd = 0;
    #1 d = h_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] d, lo;
    repeat (3) @(negedge clk);
    #1 chk(h_rdata === 32'h0 && reg_we === '0, "R10 reset", h_rdata, 32'h0);
    rst_n = 1;

    wr(0, 1, 0, 32'hA5A51234);
    #1 chk(bank[0] === 32'hA5A51234, "R1 full write", bank[0], 32'hA5A51234);
    wr(1, 1, 0, 32'h11112222);
    wr(1, 0, 0, 32'h0000BEEF);
    #1 chk(bank[1] === 32'h1111BEEF, "R2 lower only", bank[1], 32'h1111BEEF);
    wr(1, 0, 1, 32'h0000CAFE);
    #1 chk(bank[1] === 32'hCAFEBEEF, "R2 upper only", bank[1], 32'hCAFEBEEF);

    wr(6, 0, 0, 32'h00005678);
    #1 chk(bank[6] === 32'h0, "R3 staged no update", bank[6], 32'h0);
    wr(7, 1, 0, 32'hDEAD0001);
    #1 chk(bank[7] === 32'hDEAD0001, "R6 interleaved full write", bank[7], 32'hDEAD0001);
    wr(6, 0, 1, 32'h00001234);
    #1 chk(bank[6] === 32'h12345678, "R4 R6 commit after interleave", bank[6], 32'h12345678);
    wr(6, 0, 1, 32'h00009999);
    #1 chk(bank[6] === 32'h12345678, "R5 lone upper ignored", bank[6], 32'h12345678);

    wr(4, 0, 0, 32'h00001111);
    wr(4, 1, 0, 32'h00000042);
    wr(4, 0, 1, 32'h00007777);
    #1 chk(bank[4] === 32'h00000042, "R1 full write discards stage", bank[4], 32'h00000042);

    wr(CNT, 0, 0, 32'h0000FFFE);
    wr(CNT, 0, 1, 32'h00001234);
    #1 chk(bank[CNT] === 32'h1234FFFE, "R4 counter load", bank[CNT], 32'h1234FFFE);
    @(negedge clk); cnt_run = 1;
    rd(CNT, 0, 0, lo);
    #1 chk(lo[31:16] === 16'h0, "R10 half read upper zero", lo, {16'h0, lo[15:0]});
    repeat (4) @(negedge clk);
    rd(CNT, 0, 1, d);
    chk(d === {16'h0, (lo[15:0] >= 16'hFFFE) ? 16'h1234 : 16'h1235}, "R7 counter snapshot", d,
        {16'h0, (lo[15:0] >= 16'hFFFE) ? 16'h1234 : 16'h1235});
    rd(CNT, 1, 0, d);
    chk(d[31:16] === 16'h1235, "R9 live full read", d, 32'h12350000);

    @(negedge clk); cnt_run = 0; cap_ev = 1;
    @(negedge clk); cap_ev = 0;
    wr(2, 1, 0, 32'hAAAA0001);
    wr(3, 1, 0, 32'h5555000F);
    rd(2, 0, 0, d);
    chk(d === 32'h00000001, "R7 capture lower", d, 32'h00000001);
    wr(2, 1, 0, 32'h77770000);
    rd(3, 0, 0, d);
    chk(d === 32'h0000000F, "R8 other capture lower", d, 32'h0000000F);
    rd(2, 1, 0, d);
    chk(d === 32'h77770000, "R9 full read live", d, 32'h77770000);
    rd(2, 0, 1, d);
    chk(d === 32'h0000AAAA, "R8 snapshot kept", d, 32'h0000AAAA);
    rd(3, 0, 1, d);
    chk(d === 32'h00005555, "R8 second snapshot", d, 32'h00005555);
    rd(0, 0, 1, d);
    chk(d === 32'h0000A5A5, "R9 live upper non-snapshot", d, 32'h0000A5A5);
    rd(1, 0, 0, d);
    chk(d === 32'h0000BEEF, "R10 lower half data", d, 32'h0000BEEF);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule